// File: doc/BRIEF.md
# Multi-Source Event Merger and Formatter

This block assembles complete event records from several upstream source streams, one event at a time, paced by a small queue of trigger accepts. Each accept carries a 2-bit buffer number. For every accept, the block takes exactly one event's worth of words from each source in a fixed source order. A source marks its final word of an event with an end-of-event flag. Every word also carries a buffer tag, which the block compares against the queued buffer number.

The merged record goes out as a stream of 32-bit words with valid/ready flow control. The record starts with a header that holds a running event count and the buffer number. The source blocks follow, and the record ends with a trailer that holds the word count and one consistency-error bit per source. A flag on the trailer word reports when any source disagreed. The block sits in front of a point-to-point link at a nominal 40 MHz word rate. It tolerates arbitrary stalls from that link.

Top module: `evt_merge_fmt`

## Requirements
- R1: Up to four accepted triggers are held pending, and exactly one record is emitted per accepted trigger, in the order the triggers arrived.
- R2: The first word of a record is the header: bits 23:0 hold the event count, bits 25:24 hold the trigger's buffer number, and bits 31:26 are zero.
- R3: After the header come the words of source 0, up to and including its end-of-event word, then those of source 1, and so on; data words are copied unchanged, and no source word is taken before its event's trigger.
- R4: The last word of a record is the trailer: bits 15:0 hold the number of source words in the record, bit 16+s is the error bit of source s, and the other bits are zero; `out_last` is high on the trailer word and low on every other word.
- R5: A source word whose tag differs from the record's buffer number sets that source's error bit; `out_err` is high on a trailer with any error bit set, and low on all other words.
- R6: The event count is zero for the first record after reset and increases by one for each record.
- R7: A trigger that arrives while four triggers are pending (from acceptance until their trailer is presented) is discarded, and `trig_overflow` rises and stays high until reset.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data`.
- R9: After reset `out_valid`, every `src_ready` bit and `trig_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | One-cycle trigger accept |
| trig_buf | input | 2 | Buffer number of the trigger |
| src_valid | input | NSRC | Per-source word valid |
| src_data | input | NSRC x 32 | Per-source data word |
| src_eoe | input | NSRC | Per-source end-of-event mark |
| src_tag | input | NSRC x 2 | Per-source buffer tag |
| src_ready | output | NSRC | Per-source word taken |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the trailer word |
| out_err | output | 1 | Trailer reports a source mismatch |
| trig_overflow | output | 1 | Sticky: a trigger was dropped |

## Verification
The hardest state to reach is a full trigger queue with a fifth accept arriving. From the ports this only happens when no trailer can be produced while the triggers come in. The bench gets there by holding `out_ready` low once the first header is loaded. This leaves the builder stalled and the queue unable to drain while five accepts arrive back to back. It then releases the link and confirms that only four records come out and that the overflow flag stays set. A second phase runs random event lengths, tag mismatches and random backpressure against a behavioural model of the record stream.

// File: rtl/emf_pkg.sv
package emf_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BODY = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;
endpackage

// File: rtl/emf_trigq.sv
module emf_trigq #(
    parameter int DEPTH = 4,
    parameter int BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [BW-1:0] push_buf,
    input  logic          pop,
    output logic [BW-1:0] head_buf,
    output logic          not_empty,
    output logic          overflow
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] slots;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } tq_t;

    tq_t q_q, q_d;
    logic full, do_push, do_pop;

    always_comb begin
        q_d     = q_q;
        full    = (q_q.cnt == CW'(DEPTH));
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && !full;
        if (push && full) begin
            q_d.ovf = 1'b1;
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + PW'(1);
        end
        if (do_push) begin
            q_d.slots[q_q.wr] = push_buf;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + PW'(1);
        end
        q_d.cnt = q_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_buf  = q_q.slots[q_q.rd];
    assign not_empty = (q_q.cnt != '0);
    assign overflow  = q_q.ovf;

    assert_queue_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (q_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/emf_srcmux.sv
module emf_srcmux #(
    parameter int NSRC = 2,
    parameter int DW   = 32,
    parameter int TW   = 2,
    parameter int SW   = 1
) (
    input  logic [SW-1:0]            sel,
    input  logic [NSRC-1:0]          v_in,
    input  logic [NSRC-1:0][DW-1:0]  d_in,
    input  logic [NSRC-1:0]          e_in,
    input  logic [NSRC-1:0][TW-1:0]  t_in,
    input  logic                     take,
    output logic                     v_o,
    output logic [DW-1:0]            d_o,
    output logic                     e_o,
    output logic [TW-1:0]            t_o,
    output logic [NSRC-1:0]          rdy_o
);
    always_comb begin
        v_o = 1'b0;
        d_o = '0;
        e_o = 1'b0;
        t_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SW'(i)) begin
                v_o = v_in[i];
                d_o = d_in[i];
                e_o = e_in[i];
                t_o = t_in[i];
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_rdy
        assign rdy_o[g] = take && (sel == SW'(g));
    end
endmodule

// File: rtl/evt_merge_fmt.sv
module evt_merge_fmt
    import emf_pkg::*;
#(
    parameter int NSRC   = 2,
    parameter int QDEPTH = 4,
    parameter int BUF_W  = 2,
    parameter int EVC_W  = 24,
    parameter int WCNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trig_valid,
    input  logic [BUF_W-1:0]            trig_buf,
    input  logic [NSRC-1:0]             src_valid,
    input  logic [NSRC-1:0][31:0]       src_data,
    input  logic [NSRC-1:0]             src_eoe,
    input  logic [NSRC-1:0][BUF_W-1:0]  src_tag,
    output logic [NSRC-1:0]             src_ready,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [31:0]                 out_data,
    output logic                        out_last,
    output logic                        out_err,
    output logic                        trig_overflow
);
    localparam int DW = 32;
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        phase_e            st;
        logic [SW-1:0]     sidx;
        logic [WCNT_W-1:0] wcnt;
        logic [NSRC-1:0]   errs;
        logic [EVC_W-1:0]  evcnt;
        logic              ov;
        logic [DW-1:0]     od;
        logic              olast;
        logic              oerr;
    } core_t;

    core_t c_q, c_d;

    logic [BUF_W-1:0] head_buf;
    logic             q_nonempty;
    logic             pop_c;
    logic             take_c;
    logic             m_valid, m_eoe;
    logic [DW-1:0]    m_data;
    logic [BUF_W-1:0] m_tag;
    logic             load;

    emf_trigq #(.DEPTH(QDEPTH), .BW(BUF_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (trig_valid),
        .push_buf  (trig_buf),
        .pop       (pop_c),
        .head_buf  (head_buf),
        .not_empty (q_nonempty),
        .overflow  (trig_overflow)
    );

    emf_srcmux #(.NSRC(NSRC), .DW(DW), .TW(BUF_W), .SW(SW)) u_mux (
        .sel   (c_q.sidx),
        .v_in  (src_valid),
        .d_in  (src_data),
        .e_in  (src_eoe),
        .t_in  (src_tag),
        .take  (take_c),
        .v_o   (m_valid),
        .d_o   (m_data),
        .e_o   (m_eoe),
        .t_o   (m_tag),
        .rdy_o (src_ready)
    );

    always_comb begin
        c_d    = c_q;
        take_c = 1'b0;
        pop_c  = 1'b0;
        load   = !c_q.ov || out_ready;
        if (load) begin
            c_d.ov    = 1'b0;
            c_d.olast = 1'b0;
            c_d.oerr  = 1'b0;
            case (c_q.st)
                PH_IDLE: begin
                    if (q_nonempty) begin
                        c_d.ov = 1'b1;
                        c_d.od = '0;
                        c_d.od[EVC_W-1:0]      = c_q.evcnt;
                        c_d.od[EVC_W +: BUF_W] = head_buf;
                        c_d.st   = PH_BODY;
                        c_d.sidx = '0;
                        c_d.wcnt = '0;
                        c_d.errs = '0;
                    end
                end
                PH_BODY: begin
                    if (m_valid) begin
                        take_c   = 1'b1;
                        c_d.ov   = 1'b1;
                        c_d.od   = m_data;
                        c_d.wcnt = c_q.wcnt + WCNT_W'(1);
                        if (m_tag != head_buf) begin
                            c_d.errs[c_q.sidx] = 1'b1;
                        end
                        if (m_eoe) begin
                            if (c_q.sidx == SW'(NSRC - 1)) c_d.st = PH_TAIL;
                            else                           c_d.sidx = c_q.sidx + SW'(1);
                        end
                    end
                end
                PH_TAIL: begin
                    pop_c  = 1'b1;
                    c_d.ov = 1'b1;
                    c_d.od = '0;
                    c_d.od[WCNT_W-1:0]     = c_q.wcnt;
                    c_d.od[WCNT_W +: NSRC] = c_q.errs;
                    c_d.olast = 1'b1;
                    c_d.oerr  = |c_q.errs;
                    c_d.evcnt = c_q.evcnt + EVC_W'(1);
                    c_d.st    = PH_IDLE;
                end
                default: c_d.st = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign out_valid = c_q.ov;
    assign out_data  = c_q.od;
    assign out_last  = c_q.olast;
    assign out_err   = c_q.oerr;

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    assert_take_needs_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ready) |-> (!out_valid || out_ready));
    assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));
    assert_last_is_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    assert_err_on_trailer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_last);
    assert_no_take_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q_nonempty |-> (src_ready == '0));
endmodule

// File: tb/sim_evt_merge_fmt.sv
`timescale 1ns/1ps
module sim_evt_merge_fmt;
    localparam int NSRC = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n;
    logic                 trig_valid;
    logic [1:0]           trig_buf;
    logic [NSRC-1:0]      src_valid;
    logic [NSRC-1:0][31:0] src_data;
    logic [NSRC-1:0]      src_eoe;
    logic [NSRC-1:0][1:0] src_tag;
    logic [NSRC-1:0]      src_ready;
    logic                 out_valid;
    logic                 out_ready;
    logic [31:0]          out_data;
    logic                 out_last;
    logic                 out_err;
    logic                 trig_overflow;

    evt_merge_fmt u0 (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_buf(trig_buf),
        .src_valid(src_valid), .src_data(src_data), .src_eoe(src_eoe), .src_tag(src_tag),
        .src_ready(src_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_err(out_err),
        .trig_overflow(trig_overflow)
    );

    logic [34:0] sq0[$];
    logic [34:0] sq1[$];
    logic [1:0]  tq[$];
    logic [35:0] expq[$];

    int checks = 0, fails = 0, cycles = 0, outstanding = 0;
    bit timeout = 0, rdy_en = 1, prev_stall = 0;
    logic [31:0] prev_data;
    logic [23:0] evc_m;

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_event(input logic [1:0] b, input int n0, input int n1,
                             input bit bad0, input bit bad1, input bit with_trig);
        logic [31:0] d, t;
        expq.push_back({2'd0, 2'b00, 6'b0, b, evc_m});
        evc_m = evc_m + 24'd1;
        for (int k = 0; k < n0; k++) begin
            d = $urandom;
            sq0.push_back({(k == n0 - 1), ((bad0 && k == n0 / 2) ? (b ^ 2'b01) : b), d});
            expq.push_back({2'd1, 2'b00, d});
        end
        for (int k = 0; k < n1; k++) begin
            d = $urandom;
            sq1.push_back({(k == n1 - 1), ((bad1 && k == n1 / 2) ? (b ^ 2'b10) : b), d});
            expq.push_back({2'd1, 2'b00, d});
        end
        t = 32'(n0 + n1) | (32'(bad0) << 16) | (32'(bad1) << 17);
        expq.push_back({2'd2, (bad0 | bad1), 1'b1, t});
        if (with_trig) tq.push_back(b);
        outstanding++;
    endtask

    task automatic step();
        bit ohs, h0, h1;
        logic [35:0] e;
        logic [34:0] w;
        @(negedge clk);
        cycles++;
        if (cycles > 150000) timeout = 1;
        if (prev_stall)
            check(out_valid && out_data == prev_data, "R8 stall hold",
                  {3'b0, out_valid, out_data}, {4'b0001, prev_data});
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        ohs = out_valid && out_ready;
        if (ohs) begin
            if (expq.size() == 0) begin
                check(0, "R1 unexpected word", {2'b0, out_err, out_last, out_data}, '0);
            end else begin
                e = expq.pop_front();
                check({out_err, out_last, out_data} == e[33:0],
                      (e[35:34] == 2'd0) ? "R1 R2 R6 header" :
                      (e[35:34] == 2'd1) ? "R3 data" : "R4 R5 trailer",
                      {2'b0, out_err, out_last, out_data}, {2'b0, e[33:0]});
                if (out_last && outstanding > 0) outstanding--;
            end
        end
        h0 = src_valid[0] && src_ready[0];
        h1 = src_valid[1] && src_ready[1];
        @(posedge clk);
        #1;
        if (h0) w = sq0.pop_front();
        if (h1) w = sq1.pop_front();
        src_valid[0] = (sq0.size() != 0);
        if (sq0.size() != 0) {src_eoe[0], src_tag[0], src_data[0]} = sq0[0];
        src_valid[1] = (sq1.size() != 0);
        if (sq1.size() != 0) {src_eoe[1], src_tag[1], src_data[1]} = sq1[0];
        if (tq.size() != 0) begin
            trig_valid = 1'b1;
            trig_buf   = tq.pop_front();
        end else begin
            trig_valid = 1'b0;
        end
        out_ready = rdy_en && (($urandom % 4) != 0);
    endtask

    task automatic do_reset();
        sq0.delete(); sq1.delete(); tq.delete(); expq.delete();
        rst_n = 1'b0; trig_valid = 1'b0; trig_buf = '0;
        src_valid = '0; src_data = '0; src_eoe = '0; src_tag = '0;
        out_ready = 1'b0; outstanding = 0; evc_m = '0; prev_stall = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && src_ready == '0 && !trig_overflow, "R9 reset state",
              {33'b0, out_valid, |src_ready, trig_overflow}, '0);
    endtask

    initial begin
        do_reset();
        // Phase 1: fill the trigger queue while the link is stalled.
        rdy_en = 0;
        add_event(2'd1, 2, 1, 0, 0, 0);
        add_event(2'd2, 1, 3, 1, 0, 0);
        add_event(2'd3, 3, 2, 0, 1, 0);
        add_event(2'd0, 1, 1, 1, 1, 0);
        tq.push_back(2'd1); tq.push_back(2'd2); tq.push_back(2'd3);
        tq.push_back(2'd0); tq.push_back(2'd2);
        repeat (5) step();
        check(!trig_overflow, "R7 no overflow at four pending", {35'b0, trig_overflow}, '0);
        repeat (3) step();
        check(trig_overflow, "R7 fifth trigger overflow", {35'b0, trig_overflow}, 36'd1);
        rdy_en = 1;
        while (expq.size() != 0 && !timeout) step();
        repeat (40) step();
        check(trig_overflow, "R7 overflow sticky", {35'b0, trig_overflow}, 36'd1);
        check(sq0.size() == 0 && sq1.size() == 0, "R3 all source words taken",
              36'(sq0.size() + sq1.size()), '0);

        // Phase 2: random traffic and backpressure.
        do_reset();
        begin
            int made = 0;
            while (made < 30 && !timeout) begin
                if (outstanding < 4 && ($urandom % 3) == 0) begin
                    add_event(2'($urandom), 1 + int'($urandom % 4), 1 + int'($urandom % 4),
                              ($urandom % 5) == 0, ($urandom % 5) == 0, 1);
                    made++;
                end
                step();
            end
        end
        while (expq.size() != 0 && !timeout) step();
        repeat (40) step();
        check(!trig_overflow, "R7 no overflow under limit", {35'b0, trig_overflow}, '0);
        check(sq0.size() == 0 && sq1.size() == 0, "R3 phase2 sources drained",
              36'(sq0.size() + sq1.size()), '0);
        if (timeout) begin
            checks++; fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=0 pending words", expq.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule